// File: doc/BRIEF.md
# LIN Slave Baud Divider Update Controller

This block owns the active baud-rate divider of a LIN slave receiver and decides when software writes to the integer and fractional prescaler fields take effect. The divider is a fixed-point value: an integer field in the upper bits and a fractional field in the lower bits. Software writes each field through its own strobe. An update-policy bit chooses between two policies. With the bit clear, a write takes effect at once. With the bit set, the write is only staged, and it moves into the active divider when the next character arrives. A character arrives when the receive-full flag rises.

An auto-synchronization unit can load a measured divider at any time, and it always wins. A software write in the same cycle is dropped, and any value already staged is replaced by the measured one. Hardware clears the policy bit on every received character, so a deferred update applies to one character only. The deferred policy works only when the mode input selects slave operation. In any other mode, writes are immediate.

Top module: `lin_div_ctrl`

## Requirements
- R1: After reset, `div_o` equals the parameter `DIV_RST` (default 12'h100) and `method_o` is 0.
- R2: When the deferred policy is not active, an integer write with no auto-sync update in that cycle sets `div_o[11:4]` to the written byte on the next cycle. `div_o[3:0]` is left unchanged.
- R3: When the deferred policy is not active, a fractional write with no auto-sync update in that cycle sets `div_o[3:0]` to the written nibble on the next cycle. `div_o[11:4]` is left unchanged.
- R4: An auto-sync update loads `sync_div_i` into `div_o` on the next cycle. Software writes in the same cycle are discarded, and the loaded value also replaces any staged value.
- R5: The deferred policy is active when `lin_mode_i` is 2'b11 and `method_o` is 1. While it is active, writes leave `div_o` unchanged. On the next rising edge of `rx_full_i`, the staged fields become `div_o` one cycle later. A write in the same cycle as that edge is included.
- R6: A `rx_full_i` that stays high without a new rising edge does not commit a staged value.
- R7: If the deferred policy is active and no write happens before the rising edge of `rx_full_i`, `div_o` keeps its prior value.
- R8: A rising edge of `rx_full_i` clears `method_o` on the next cycle. This takes priority over a software write of the bit in the same cycle. Otherwise `ctl_wr_i` loads `ctl_wdata_i` into the bit.
- R9: After software clears `method_o` before a character arrives, writes take effect immediately again.
- R10: When `lin_mode_i` is not 2'b11, `method_o` = 1 has no effect. Writes are immediate and a rising edge of `rx_full_i` commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_mode_i | input | 2 | Mode select; 2'b11 is slave operation |
| ctl_wr_i | input | 1 | Write strobe for the update-policy bit |
| ctl_wdata_i | input | 1 | New policy bit value |
| int_wr_i | input | 1 | Integer prescaler write strobe |
| int_wdata_i | input | 8 | Integer prescaler data |
| frac_wr_i | input | 1 | Fractional prescaler write strobe |
| frac_wdata_i | input | 4 | Fractional prescaler data |
| rx_full_i | input | 1 | Receive-full flag; its rising edge marks a character |
| sync_upd_i | input | 1 | Auto-sync update request |
| sync_div_i | input | 12 | Divider computed by auto-sync |
| div_o | output | 12 | Active divider {integer, fraction} |
| method_o | output | 1 | Update-policy bit as read back |

## Verification
The hardest case to reach is a staged value that is changed before it commits. Examples are an auto-sync load arriving between the write and the character, a write landing in the same cycle as the receive-full edge, and the flag staying high so that no new edge occurs. Random stimulus reaches these only rarely. Directed sequences therefore set the policy bit, stage split integer and fractional writes, and then place the sync pulse or the edge on chosen cycles. A weighted random phase then mixes all strobes, and a reference model in the bench follows the requirements.

// File: rtl/lin_div_pkg.sv
package lin_div_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SYNC   = 2'd1,
    SRC_COMMIT = 2'd2,
    SRC_WRITE  = 2'd3
  } upd_src_e;

  localparam logic [1:0] MODE_SLAVE = 2'b11;
endpackage

// File: rtl/lin_div_edge.sv
module lin_div_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/lin_div_mode.sv
module lin_div_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic ctl_wdata_i,
  input  logic rx_rise_i,
  output logic method_o
);
  logic method_q;

  // hardware clear outranks software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        method_q <= 1'b0;
    else if (rx_rise_i) method_q <= 1'b0;
    else if (ctl_wr_i)  method_q <= ctl_wdata_i;
  end

  assign method_o = method_q;

  assert_hw_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rise_i |=> !method_q);
endmodule

// File: rtl/lin_div_arb.sv
module lin_div_arb
  import lin_div_pkg::*;
(
  input  logic [1:0] lin_mode_i,
  input  logic       method_i,
  input  logic       rx_rise_i,
  input  logic       sync_i,
  input  logic       wr_any_i,
  output logic       deferred_o,
  output upd_src_e   src_o
);
  always_comb begin
    deferred_o = (lin_mode_i == MODE_SLAVE) && method_i;
    if (sync_i)                    src_o = SRC_SYNC;
    else if (deferred_o && rx_rise_i) src_o = SRC_COMMIT;
    else if (wr_any_i && !deferred_o) src_o = SRC_WRITE;
    else                           src_o = SRC_NONE;
  end

  always_comb begin
    assert_one_src_R4: assert (!(sync_i && src_o != SRC_SYNC));
  end
endmodule

// File: rtl/lin_div_regs.sv
module lin_div_regs
  import lin_div_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = INT_W + FRAC_W,
  parameter logic [DIV_W-1:0] DIV_RST = 12'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  upd_src_e          src_i,
  input  logic              deferred_i,
  input  logic              int_wr_i,
  input  logic [INT_W-1:0]  int_wdata_i,
  input  logic              frac_wr_i,
  input  logic [FRAC_W-1:0] frac_wdata_i,
  input  logic [DIV_W-1:0]  sync_div_i,
  output logic [DIV_W-1:0]  div_o
);
  logic [DIV_W-1:0] act_q, stage_q, act_mrg, stage_mrg;

  function automatic logic [DIV_W-1:0] merge(input logic [DIV_W-1:0] base);
    logic [DIV_W-1:0] r;
    r = base;
    if (int_wr_i)  r[DIV_W-1 -: INT_W] = int_wdata_i;
    if (frac_wr_i) r[FRAC_W-1:0]       = frac_wdata_i;
    return r;
  endfunction

  assign act_mrg   = merge(act_q);
  assign stage_mrg = merge(stage_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= DIV_RST;
      stage_q <= DIV_RST;
    end else begin
      unique case (src_i)
        SRC_SYNC: begin
          act_q   <= sync_div_i;
          stage_q <= sync_div_i;
        end
        SRC_COMMIT: begin
          act_q   <= stage_mrg;
          stage_q <= stage_mrg;
        end
        SRC_WRITE: begin
          act_q   <= act_mrg;
          stage_q <= act_mrg;
        end
        default: begin
          if (deferred_i && (int_wr_i || frac_wr_i)) stage_q <= stage_mrg;
        end
      endcase
    end
  end

  assign div_o = act_q;

  assert_defer_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_NONE) |=> $stable(act_q));
  assert_commit_stage_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_COMMIT) |=> act_q == stage_q);
endmodule

// File: rtl/lin_div_ctrl.sv
module lin_div_ctrl
  import lin_div_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = INT_W + FRAC_W,
  parameter logic [DIV_W-1:0] DIV_RST = 12'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        lin_mode_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_wdata_i,
  input  logic              int_wr_i,
  input  logic [INT_W-1:0]  int_wdata_i,
  input  logic              frac_wr_i,
  input  logic [FRAC_W-1:0] frac_wdata_i,
  input  logic              rx_full_i,
  input  logic              sync_upd_i,
  input  logic [DIV_W-1:0]  sync_div_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              method_o
);
  logic     rx_rise, deferred;
  upd_src_e src;

  lin_div_edge u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (rx_full_i), .rise_o (rx_rise)
  );

  lin_div_mode u_mode (
    .clk_i (clk_i), .rst_ni (rst_ni), .ctl_wr_i (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i), .rx_rise_i (rx_rise), .method_o (method_o)
  );

  lin_div_arb u_arb (
    .lin_mode_i (lin_mode_i), .method_i (method_o), .rx_rise_i (rx_rise),
    .sync_i (sync_upd_i), .wr_any_i (int_wr_i | frac_wr_i),
    .deferred_o (deferred), .src_o (src)
  );

  lin_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DIV_RST(DIV_RST)) u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .src_i (src), .deferred_i (deferred),
    .int_wr_i (int_wr_i), .int_wdata_i (int_wdata_i),
    .frac_wr_i (frac_wr_i), .frac_wdata_i (frac_wdata_i),
    .sync_div_i (sync_div_i), .div_o (div_o)
  );

  assert_sync_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_upd_i |=> div_o == $past(sync_div_i));
  assert_imm_int_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(lin_mode_i == MODE_SLAVE && method_o) && int_wr_i && !sync_upd_i)
    |=> div_o[DIV_W-1 -: INT_W] == $past(int_wdata_i));
  assert_imm_frac_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(lin_mode_i == MODE_SLAVE && method_o) && frac_wr_i && !sync_upd_i)
    |=> div_o[FRAC_W-1:0] == $past(frac_wdata_i));
endmodule

// File: tb/lin_div_ctrl_bench.sv
`timescale 1ns/1ps
module lin_div_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        ctl_wr = 0, ctl_d = 0, int_wr = 0, frac_wr = 0, rx = 0, sync = 0;
  logic [7:0]  int_d = 0;
  logic [3:0]  frac_d = 0;
  logic [11:0] sync_d = 0, div;
  logic        meth;

  logic [11:0] m_div, m_stage;
  logic        m_meth, m_rxq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lin_div_ctrl u_lin_div_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .lin_mode_i (mode), .ctl_wr_i (ctl_wr),
    .ctl_wdata_i (ctl_d), .int_wr_i (int_wr), .int_wdata_i (int_d),
    .frac_wr_i (frac_wr), .frac_wdata_i (frac_d), .rx_full_i (rx),
    .sync_upd_i (sync), .sync_div_i (sync_d), .div_o (div), .method_o (meth)
  );

  function automatic logic [11:0] mrg(input logic [11:0] b);
    logic [11:0] r = b;
    if (int_wr)  r[11:4] = int_d;
    if (frac_wr) r[3:0]  = frac_d;
    return r;
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    ctl_wr = 0; int_wr = 0; frac_wr = 0; sync = 0;
  endtask

  // one clock with current inputs, reference model per requirements, then compare
  task automatic tick(input string req);
    logic rise, dfr;
    @(posedge clk);
    rise = rx & ~m_rxq;
    dfr  = (mode == 2'b11) && m_meth;
    if (sync) begin m_div = sync_d; m_stage = sync_d; end
    else if (dfr && rise) begin m_stage = mrg(m_stage); m_div = m_stage; end
    else if (int_wr || frac_wr) begin
      if (dfr) m_stage = mrg(m_stage);
      else begin m_div = mrg(m_div); m_stage = m_div; end
    end
    m_meth = rise ? 1'b0 : (ctl_wr ? ctl_d : m_meth);
    m_rxq  = rx;
    @(negedge clk);
    chk(req, div, m_div);
    chk({req, " method"}, {11'd0, meth}, {11'd0, m_meth});
    clr();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    m_div = 12'h100; m_stage = 12'h100; m_meth = 0; m_rxq = 0;
    repeat (3) @(negedge clk);
    chk("R1", div, 12'h100);
    chk("R1 method", {11'd0, meth}, 12'd0);
    rst_n = 1;
    @(negedge clk);

    // R2, R3 immediate
    int_wr = 1; int_d = 8'hA5; tick("R2");
    chk("R2", div, 12'hA50);
    frac_wr = 1; frac_d = 4'h7; tick("R3");
    chk("R3", div, 12'hA57);
    // R4 sync beats write
    sync = 1; sync_d = 12'h3C2; int_wr = 1; int_d = 8'hFF; tick("R4");
    chk("R4", div, 12'h3C2);
    // R5 deferred
    ctl_wr = 1; ctl_d = 1; tick("R5");
    int_wr = 1; int_d = 8'h12; tick("R5");
    chk("R5 held", div, 12'h3C2);
    frac_wr = 1; frac_d = 4'h9; tick("R5");
    rx = 1; tick("R5");
    chk("R5 commit", div, 12'h129);
    chk("R8 cleared", {11'd0, meth}, 12'd0);
    // R6 level held, no new edge
    ctl_wr = 1; ctl_d = 1; tick("R6");
    int_wr = 1; int_d = 8'h44; tick("R6");
    tick("R6"); tick("R6");
    chk("R6", div, 12'h129);
    rx = 0; tick("R6");
    rx = 1; tick("R5");
    chk("R5 late edge", div, 12'h449);
    // R4 sync replaces staged value
    rx = 0; ctl_wr = 1; ctl_d = 1; tick("R4");
    int_wr = 1; int_d = 8'h77; tick("R4");
    sync = 1; sync_d = 12'h5A1; tick("R4");
    rx = 1; tick("R4");
    chk("R4 staged replaced", div, 12'h5A1);
    // R7 reload with nothing staged
    rx = 0; ctl_wr = 1; ctl_d = 1; tick("R7");
    rx = 1; tick("R7");
    chk("R7", div, 12'h5A1);
    // R8 hw clear beats sw set
    rx = 0; tick("R8");
    rx = 1; ctl_wr = 1; ctl_d = 1; tick("R8");
    chk("R8", {11'd0, meth}, 12'd0);
    // R9 sw clear then immediate
    rx = 0; ctl_wr = 1; ctl_d = 1; tick("R9");
    ctl_wr = 1; ctl_d = 0; tick("R9");
    int_wr = 1; int_d = 8'h2B; tick("R9");
    chk("R9", div, 12'h2B1);
    // R10 non-slave mode
    ctl_wr = 1; ctl_d = 1; tick("R10");
    mode = 2'b10; frac_wr = 1; frac_d = 4'hE; tick("R10");
    chk("R10", div, 12'h2BE);
    rx = 1; tick("R10");
    chk("R10 no commit", div, 12'h2BE);
    mode = 2'b11; rx = 0; tick("R10");

    // weighted random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      mode    = (r[2:0] == 0) ? 2'(r[4:3]) : 2'b11;
      ctl_wr  = (r[7:5] == 0); ctl_d = r[8];
      int_wr  = (r[10:9] == 0); int_d = 8'($urandom);
      frac_wr = (r[12:11] == 0); frac_d = 4'($urandom);
      rx      = (r[15:13] < 2) ? ~rx : rx;
      sync    = (r[19:16] == 0); sync_d = 12'($urandom);
      if (sync) tick("R4");
      else if (mode == 2'b11 && m_meth) tick("R5");
      else if (mode != 2'b11) tick("R10");
      else tick("R2");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule